// File: doc/BRIEF.md
# Delayed Transaction Retry Arbiter

This block sits on the target side of a bus bridge. For every request strobe it decides whether the request opens a new delayed transaction, gets a retry, or is completed from a finished entry. It holds a small queue of outstanding delayed requests. Each entry is keyed by its address, its bus command and its direction. The block records whether each entry has received its far-side completion, and it keeps a return queue so that completions are handed out in the order they arrived.

The decision takes lock state into account, as well as a latency estimate for accepting the request, any prefetch discard that is in progress, and posted writes that must stay ahead of read completions. The bus-level response to a newly queued request is a retry. The separate code for a newly queued request tells the surrounding logic that a far-side transaction was launched.

Top module: `dtr_arbiter`

## Requirements
- R1: One cycle after a cycle with `req_valid` high, `dec_valid` is high for exactly one cycle. The code on `dec_code` is 1 for a newly queued request, 2 for a retry and 3 for a completion. `dec_valid` stays low in every cycle that does not follow a strobe.
- R2: A request passes all gates when it is not gated by lock, latency or discard. If such a request matches no entry and a free entry exists, it gets code 1, and `dec_tag` is the lowest-numbered free entry. That entry becomes pending. A request that gets a retry changes no entry.
- R3: A request whose address, command and direction equal those of a pending entry is retried. No second entry is created for the same key.
- R4: A completion pulse on `rsp_valid` with tag `rsp_tag` moves a pending entry to complete and appends that entry to the return queue. A completion pulse for an entry that is empty or already complete is ignored.
- R5: A request matching a complete entry that is not at the head of the return queue is retried.
- R6: A read that matches a complete entry at the head of the return queue is retried while `posted_wr_pending` is high. A write in the same situation is not affected by `posted_wr_pending`.
- R7: A request matching the complete head entry, and not blocked by R6, gets code 3 with `dec_tag` equal to the entry. That entry leaves the return queue and is empty again two cycles later. A later identical request is then queued afresh.
- R8: A request that passes all gates and matches no entry while all entries are occupied is retried.
- R9: While `lock_seq_active` is high, a request with `req_locked` low is retried.
- R10: While `tgt_bus_locked` is high, a request with `req_locked` high is retried.
- R11: A request with `req_accept_est` greater than `LAT_LIMIT` (16) is retried. An estimate equal to 16 is not retried for this reason.
- R12: A read is retried while `discard_active` is high. Writes are not affected by `discard_active`.
- R13: After reset, every entry is empty, the return queue is empty, and `dec_valid` and `dec_code` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_addr | input | AW (16) | Request address |
| req_cmd | input | CW (4) | Request bus command |
| req_rd | input | 1 | 1 for a read, 0 for a write |
| req_locked | input | 1 | Request belongs to a locked sequence |
| req_accept_est | input | LW (6) | Estimated clocks needed to accept the request |
| lock_seq_active | input | 1 | A locked sequence is being passed through |
| tgt_bus_locked | input | 1 | The target bus is locked |
| discard_active | input | 1 | Prefetched read data is being discarded |
| posted_wr_pending | input | 1 | A posted write queued ahead of completions is pending |
| rsp_valid | input | 1 | Far-side completion pulse |
| rsp_tag | input | IW (2) | Entry that the completion belongs to |
| dec_valid | output | 1 | Decision valid |
| dec_code | output | 2 | 1 newly queued, 2 retry, 3 complete |
| dec_tag | output | IW (2) | Entry for codes 1 and 3 |

## Verification
Some rules can be checked on every cycle, and the assertions cover those. They check that each decision follows its strobe. They check the lock, latency, discard, ordering and full-queue retry rules from the inputs of the previous cycle. They check that at most one entry matches a key and that the return queue never holds more than the entry count.

Some behaviour spans several requests, and only the bench's scenarios can show it. This covers the lowest-free-entry choice, completions arriving out of order, duplicate or stray completion pulses being ignored, and entries being freed and reused. The bench sweeps every combination of the gate inputs and the latency estimates around the limit, and it computes the expected code itself.

// File: rtl/dtr_pkg.sv
package dtr_pkg;

  typedef enum logic [1:0] {
    ENT_EMPTY     = 2'd0,
    ENT_PENDING   = 2'd1,
    ENT_COMPLETE  = 2'd2,
    ENT_DELIVERED = 2'd3
  } ent_state_e;

  typedef enum logic [1:0] {
    DEC_NONE       = 2'd0,
    DEC_ACCEPT_NEW = 2'd1,
    DEC_RETRY      = 2'd2,
    DEC_COMPLETE   = 2'd3
  } dec_code_e;

  typedef enum logic [3:0] {
    WHY_NONE     = 4'd0,
    WHY_LOCK_SEQ = 4'd1,
    WHY_BUS_LOCK = 4'd2,
    WHY_LATENCY  = 4'd3,
    WHY_DISCARD  = 4'd4,
    WHY_PENDING  = 4'd5,
    WHY_NOT_HEAD = 4'd6,
    WHY_ORDER    = 4'd7,
    WHY_FULL     = 4'd8,
    WHY_BUSY     = 4'd9
  } retry_why_e;

  // Gate conditions that force a retry regardless of queue contents.
  function automatic retry_why_e gate_check(
    input logic lock_seq, input logic bus_lock, input logic locked,
    input logic discard, input logic rd, input logic over_limit);
    if (lock_seq && !locked)  return WHY_LOCK_SEQ;
    if (bus_lock && locked)   return WHY_BUS_LOCK;
    if (over_limit)           return WHY_LATENCY;
    if (rd && discard)        return WHY_DISCARD;
    return WHY_NONE;
  endfunction

endpackage

// File: rtl/dtr_entry.sv
module dtr_entry
  import dtr_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc,
  input  logic          rsp_hit,
  input  logic          deliver,
  input  logic [AW-1:0] key_addr,
  input  logic [CW-1:0] key_cmd,
  input  logic          key_rd,
  output logic [1:0]    state_o,
  output logic          match,
  output logic          rsp_taken
);

  ent_state_e    state;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cmd_q;
  logic          rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ENT_EMPTY;
      addr_q <= '0;
      cmd_q  <= '0;
      rd_q   <= 1'b0;
    end else begin
      unique case (state)
        ENT_EMPTY: if (alloc) begin
          state  <= ENT_PENDING;
          addr_q <= key_addr;
          cmd_q  <= key_cmd;
          rd_q   <= key_rd;
        end
        ENT_PENDING:   if (rsp_hit) state <= ENT_COMPLETE;
        ENT_COMPLETE:  if (deliver) state <= ENT_DELIVERED;
        ENT_DELIVERED: state <= ENT_EMPTY;
        default:       state <= ENT_EMPTY;
      endcase
    end
  end

  assign state_o   = state;
  assign match     = (state != ENT_EMPTY) && (addr_q == key_addr) &&
                     (cmd_q == key_cmd) && (rd_q == key_rd);
  assign rsp_taken = rsp_hit && (state == ENT_PENDING);

endmodule

// File: rtl/dtr_retq.sv
module dtr_retq #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [IW-1:0] push_tag,
  input  logic          pop,
  output logic          head_valid,
  output logic [IW-1:0] head_tag,
  output logic [IW:0]   count
);

  logic [N-1:0][IW-1:0] slots;
  logic [IW-1:0]        wr_ptr, rd_ptr;

  function automatic logic [IW-1:0] step(input logic [IW-1:0] p);
    return (p == IW'(N - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      slots  <= '0;
    end else begin
      if (push) begin
        slots[wr_ptr] <= push_tag;
        wr_ptr        <= step(wr_ptr);
      end
      if (pop) rd_ptr <= step(rd_ptr);
      count <= count + (IW+1)'(push) - (IW+1)'(pop);
    end
  end

  assign head_valid = (count != '0);
  assign head_tag   = slots[rd_ptr];

endmodule

// File: rtl/dtr_decide.sv
module dtr_decide
  import dtr_pkg::*;
#(
  parameter int N         = 4,
  parameter int IW        = 2,
  parameter int LW        = 6,
  parameter int LAT_LIMIT = 16
) (
  input  logic                req_valid,
  input  logic                req_rd,
  input  logic                req_locked,
  input  logic [LW-1:0]       req_est,
  input  logic                lock_seq,
  input  logic                bus_lock,
  input  logic                discard,
  input  logic                posted_pend,
  input  logic [N-1:0]        match_vec,
  input  logic [N-1:0][1:0]   state_vec,
  input  logic                head_valid,
  input  logic [IW-1:0]       head_tag,
  output dec_code_e           code,
  output logic [IW-1:0]       tag,
  output retry_why_e          why,
  output logic [N-1:0]        alloc_vec,
  output logic [N-1:0]        deliver_vec,
  output logic                match_any,
  output logic                full,
  output logic                head_match
);

  function automatic logic [IW-1:0] first_one(input logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) if (v[i]) r = IW'(i);
    return r;
  endfunction

  logic [N-1:0]  free_vec;
  logic [IW-1:0] match_idx, free_idx;
  logic [1:0]    m_state;
  logic          over_limit;
  retry_why_e    gate_why;

  for (genvar g = 0; g < N; g++) begin : g_free
    assign free_vec[g] = (state_vec[g] == ENT_EMPTY);
  end

  assign match_any  = |match_vec;
  assign full       = ~|free_vec;
  assign match_idx  = first_one(match_vec);
  assign free_idx   = first_one(free_vec);
  assign m_state    = state_vec[match_idx];
  assign head_match = head_valid && (head_tag == match_idx);
  assign over_limit = (int'(req_est) > LAT_LIMIT);
  assign gate_why   = gate_check(lock_seq, bus_lock, req_locked, discard,
                                 req_rd, over_limit);

  always_comb begin
    code        = DEC_NONE;
    tag         = '0;
    why         = WHY_NONE;
    alloc_vec   = '0;
    deliver_vec = '0;
    if (req_valid) begin
      code = DEC_RETRY;
      if (gate_why != WHY_NONE) begin
        why = gate_why;
      end else if (match_any) begin
        tag = match_idx;
        if (m_state == ENT_PENDING)      why = WHY_PENDING;
        else if (m_state != ENT_COMPLETE) why = WHY_BUSY;
        else if (!head_match)             why = WHY_NOT_HEAD;
        else if (req_rd && posted_pend)   why = WHY_ORDER;
        else begin
          code                   = DEC_COMPLETE;
          deliver_vec[match_idx] = 1'b1;
        end
      end else if (full) begin
        why = WHY_FULL;
      end else begin
        code                = DEC_ACCEPT_NEW;
        tag                 = free_idx;
        alloc_vec[free_idx] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dtr_arbiter.sv
module dtr_arbiter
  import dtr_pkg::*;
#(
  parameter int N         = 4,
  parameter int AW        = 16,
  parameter int CW        = 4,
  parameter int LW        = 6,
  parameter int LAT_LIMIT = 16,
  localparam int IW       = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] req_cmd,
  input  logic          req_rd,
  input  logic          req_locked,
  input  logic [LW-1:0] req_accept_est,
  input  logic          lock_seq_active,
  input  logic          tgt_bus_locked,
  input  logic          discard_active,
  input  logic          posted_wr_pending,
  input  logic          rsp_valid,
  input  logic [IW-1:0] rsp_tag,
  output logic          dec_valid,
  output logic [1:0]    dec_code,
  output logic [IW-1:0] dec_tag
);

  logic [N-1:0]      match_vec, taken_vec, alloc_vec, deliver_vec;
  logic [N-1:0][1:0] state_vec;
  logic              head_valid, match_any, full, head_match;
  logic [IW-1:0]     head_tag, nxt_tag;
  logic [IW:0]       retq_count;
  dec_code_e         nxt_code;
  retry_why_e        nxt_why;
  logic              retq_push, retq_pop;

  for (genvar g = 0; g < N; g++) begin : g_ent
    dtr_entry #(.AW(AW), .CW(CW)) u_entry (
      .clk      (clk),
      .rst_n    (rst_n),
      .alloc    (alloc_vec[g]),
      .rsp_hit  (rsp_valid && (rsp_tag == IW'(g))),
      .deliver  (deliver_vec[g]),
      .key_addr (req_addr),
      .key_cmd  (req_cmd),
      .key_rd   (req_rd),
      .state_o  (state_vec[g]),
      .match    (match_vec[g]),
      .rsp_taken(taken_vec[g])
    );
  end

  assign retq_push = |taken_vec;
  assign retq_pop  = |deliver_vec;

  dtr_retq #(.N(N), .IW(IW)) u_retq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (retq_push),
    .push_tag  (rsp_tag),
    .pop       (retq_pop),
    .head_valid(head_valid),
    .head_tag  (head_tag),
    .count     (retq_count)
  );

  dtr_decide #(.N(N), .IW(IW), .LW(LW), .LAT_LIMIT(LAT_LIMIT)) u_decide (
    .req_valid  (req_valid),
    .req_rd     (req_rd),
    .req_locked (req_locked),
    .req_est    (req_accept_est),
    .lock_seq   (lock_seq_active),
    .bus_lock   (tgt_bus_locked),
    .discard    (discard_active),
    .posted_pend(posted_wr_pending),
    .match_vec  (match_vec),
    .state_vec  (state_vec),
    .head_valid (head_valid),
    .head_tag   (head_tag),
    .code       (nxt_code),
    .tag        (nxt_tag),
    .why        (nxt_why),
    .alloc_vec  (alloc_vec),
    .deliver_vec(deliver_vec),
    .match_any  (match_any),
    .full       (full),
    .head_match (head_match)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_code  <= DEC_NONE;
      dec_tag   <= '0;
    end else begin
      dec_valid <= req_valid;
      dec_code  <= nxt_code;
      dec_tag   <= nxt_tag;
    end
  end

endmodule

// File: rtl/dtr_arbiter_chk.sv
module dtr_arbiter_chk
  import dtr_pkg::*;
#(
  parameter int N         = 4,
  parameter int LW        = 6,
  parameter int LAT_LIMIT = 16,
  parameter int IW        = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_rd,
  input logic          req_locked,
  input logic [LW-1:0] req_accept_est,
  input logic          lock_seq_active,
  input logic          tgt_bus_locked,
  input logic          discard_active,
  input logic          posted_wr_pending,
  input logic          dec_valid,
  input logic [1:0]    dec_code,
  input logic [N-1:0]  match_vec,
  input logic          match_any,
  input logic          full,
  input logic          head_match,
  input logic [IW:0]   retq_count,
  input retry_why_e    nxt_why
);

  assert_dec_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> dec_valid);
  assert_no_spurious_dec_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !dec_valid);
  assert_unique_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));
  assert_retq_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(retq_count) <= N);
  assert_not_head_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && match_any && !head_match) |=> dec_code != DEC_COMPLETE);
  assert_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_rd && posted_wr_pending) |=> dec_code != DEC_COMPLETE);
  assert_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && full && !match_any) |=> dec_code != DEC_ACCEPT_NEW);
  assert_lock_seq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && lock_seq_active && !req_locked) |=> dec_code == DEC_RETRY);
  assert_bus_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && tgt_bus_locked && req_locked) |=> dec_code == DEC_RETRY);
  assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && int'(req_accept_est) > LAT_LIMIT) |=> dec_code == DEC_RETRY);
  assert_discard_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_rd && discard_active) |=> dec_code == DEC_RETRY);
  assert_why_retry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && nxt_why != WHY_NONE) |=> dec_code == DEC_RETRY);

endmodule

bind dtr_arbiter dtr_arbiter_chk #(.N(N), .LW(LW), .LAT_LIMIT(LAT_LIMIT), .IW(IW)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .req_valid        (req_valid),
  .req_rd           (req_rd),
  .req_locked       (req_locked),
  .req_accept_est   (req_accept_est),
  .lock_seq_active  (lock_seq_active),
  .tgt_bus_locked   (tgt_bus_locked),
  .discard_active   (discard_active),
  .posted_wr_pending(posted_wr_pending),
  .dec_valid        (dec_valid),
  .dec_code         (dec_code),
  .match_vec        (match_vec),
  .match_any        (match_any),
  .full             (full),
  .head_match       (head_match),
  .retq_count       (retq_count),
  .nxt_why          (nxt_why)
);

// File: tb/dtr_arbiter_bench.sv
`timescale 1ns/1ps
module dtr_arbiter_bench;

  localparam int ACC = 1, RTY = 2, CMP = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic [3:0]  req_cmd = '0;
  logic        req_rd = 1'b0;
  logic        req_locked = 1'b0;
  logic [5:0]  req_accept_est = '0;
  logic        lock_seq_active = 1'b0;
  logic        tgt_bus_locked = 1'b0;
  logic        discard_active = 1'b0;
  logic        posted_wr_pending = 1'b0;
  logic        rsp_valid = 1'b0;
  logic [1:0]  rsp_tag = '0;
  logic        dec_valid;
  logic [1:0]  dec_code;
  logic [1:0]  dec_tag;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dtr_arbiter u_dtr_arbiter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_cmd(req_cmd), .req_rd(req_rd), .req_locked(req_locked),
    .req_accept_est(req_accept_est), .lock_seq_active(lock_seq_active),
    .tgt_bus_locked(tgt_bus_locked), .discard_active(discard_active),
    .posted_wr_pending(posted_wr_pending), .rsp_valid(rsp_valid),
    .rsp_tag(rsp_tag), .dec_valid(dec_valid), .dec_code(dec_code),
    .dec_tag(dec_tag)
  );

  task automatic check(input string rq, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", rq, got, exp);
    end
  endtask

  // Drive one request; returns the code and tag seen one cycle later.
  task automatic send(input logic [15:0] a, input logic [3:0] c, input logic rd,
                      input logic lk, input logic [5:0] est,
                      output int code, output int tag, output int vld);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_cmd = c; req_rd = rd;
    req_locked = lk; req_accept_est = est;
    @(negedge clk);
    req_valid = 1'b0;
    code = int'(dec_code); tag = int'(dec_tag); vld = int'(dec_valid);
  endtask

  task automatic respond(input logic [1:0] t);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_tag = t;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  // Bench's own statement of the gating rules.
  function automatic bit gated(input bit ls, input bit bl, input bit lk,
                               input bit dc, input bit rd, input int est);
    return (ls & ~lk) | (bl & lk) | (est > 16) | (dc & rd);
  endfunction

  // A plain request must open entry 0 and then complete from entry 0.
  task automatic roundtrip(input logic [15:0] a, input logic rd, input string rq);
    int code, tag, vld;
    send(a, rd ? 4'h6 : 4'h7, rd, 1'b0, 6'd1, code, tag, vld);
    check({rq, " new"}, code, ACC);
    check({rq, " new tag"}, tag, 0);
    respond(2'd0);
    send(a, rd ? 4'h6 : 4'h7, rd, 1'b0, 6'd1, code, tag, vld);
    check({rq, " complete R7"}, code, CMP);
    check({rq, " complete tag R7"}, tag, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int code, tag, vld;
    repeat (3) @(negedge clk);
    check("R13 reset dec_valid", int'(dec_valid), 0);
    check("R13 reset dec_code", int'(dec_code), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle no decision", int'(dec_valid), 0);

    // Sweep every gate combination (R9 R10 R12 R2).
    for (int i = 0; i < 32; i++) begin
      bit ls, bl, lk, dc, rd;
      ls = i[0]; bl = i[1]; lk = i[2]; dc = i[3]; rd = i[4];
      lock_seq_active = ls; tgt_bus_locked = bl; discard_active = dc;
      send(16'h0100 + 16'(i), rd ? 4'h6 : 4'h7, rd, lk, 6'd3, code, tag, vld);
      lock_seq_active = 0; tgt_bus_locked = 0; discard_active = 0;
      check("R1 dec_valid after strobe", vld, 1);
      if (gated(ls, bl, lk, dc, rd, 3)) begin
        check("R9 R10 R12 gate retry", code, RTY);
      end else begin
        check("R2 ungated new", code, ACC);
        check("R2 lowest free tag", tag, 0);
        respond(2'd0);
        send(16'h0100 + 16'(i), rd ? 4'h6 : 4'h7, rd, lk, 6'd3, code, tag, vld);
        check("R7 sweep complete", code, CMP);
      end
      // A gated request leaves the queue untouched: entry 0 must be free.
      roundtrip(16'h0800 + 16'(i), 1'b1, "R2 queue untouched");
    end

    // Latency estimates around the limit (R11).
    for (int e = 14; e <= 19; e++) begin
      send(16'h0300, 4'h6, 1'b1, 1'b0, 6'(e), code, tag, vld);
      if (gated(0, 0, 0, 0, 1, e)) check("R11 over limit retry", code, RTY);
      else begin
        check("R11 within limit new", code, ACC);
        respond(2'd0);
        send(16'h0300, 4'h6, 1'b1, 1'b0, 6'(e), code, tag, vld);
        check("R11 within limit complete", code, CMP);
      end
    end

    // Fill the queue; command is part of the key (R2 R3 R8).
    send(16'h0200, 4'h6, 1'b1, 1'b0, 6'd1, code, tag, vld);
    check("R2 fill tag0", tag, 0);
    send(16'h0200, 4'hC, 1'b1, 1'b0, 6'd1, code, tag, vld);
    check("R2 other cmd new", code, ACC);
    check("R2 other cmd tag1", tag, 1);
    send(16'h0202, 4'h7, 1'b0, 1'b0, 6'd1, code, tag, vld);
    check("R2 fill tag2", tag, 2);
    send(16'h0203, 4'h6, 1'b1, 1'b0, 6'd1, code, tag, vld);
    check("R2 fill tag3", tag, 3);
    send(16'h0204, 4'h6, 1'b1, 1'b0, 6'd1, code, tag, vld);
    check("R8 full retry", code, RTY);
    send(16'h0200, 4'hC, 1'b1, 1'b0, 6'd1, code, tag, vld);
    check("R3 pending retry", code, RTY);

    // Out-of-order completions (R4 R5 R6 R7).
    respond(2'd2);
    respond(2'd0);
    send(16'h0200, 4'h6, 1'b1, 1'b0, 6'd1, code, tag, vld);
    check("R5 not head retry", code, RTY);
    respond(2'd2);  // duplicate, must be ignored
    posted_wr_pending = 1'b1;
    send(16'h0202, 4'h7, 1'b0, 1'b0, 6'd1, code, tag, vld);
    check("R6 write ignores posted", code, CMP);
    check("R7 write complete tag", tag, 2);
    send(16'h0200, 4'h6, 1'b1, 1'b0, 6'd1, code, tag, vld);
    check("R6 read behind posted retry", code, RTY);
    posted_wr_pending = 1'b0;
    send(16'h0200, 4'h6, 1'b1, 1'b0, 6'd1, code, tag, vld);
    check("R4 R7 head complete", code, CMP);
    check("R7 complete tag0", tag, 0);

    // Stray completion for an empty entry is ignored (R4), entries reused (R7).
    respond(2'd2);
    send(16'h0204, 4'h6, 1'b1, 1'b0, 6'd1, code, tag, vld);
    check("R2 reuse lowest free", tag, 0);
    send(16'h0200, 4'h6, 1'b1, 1'b0, 6'd1, code, tag, vld);
    check("R7 requeued after delivery", code, ACC);
    check("R7 requeued tag2", tag, 2);
    send(16'h0200, 4'h6, 1'b1, 1'b0, 6'd1, code, tag, vld);
    check("R4 stray completion ignored", code, RTY);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule